// File: doc/BRIEF.md
# DMA Virtual Address Translation Unit

This block sits between the peripherals of an expansion bus and main memory. It turns the virtual addresses those peripherals use for direct memory access into physical addresses. Translated addresses must fall inside a window that always ends at the top of the 32-bit space. Software sets the window size with a three-bit code. The block finds the page entry for a virtual page in a table that lives in memory. It reads that entry through a single-word read port and keeps recent results in a small fully associative cache.

Software programs the block through a simple register port. The registers set the table base, the window size and the global enable, and issue two kinds of cache invalidation: all entries, or one page. Each bus slot can also be set to skip translation. Its addresses then go straight to memory, with physical bit 30 taken from a per-slot bit. Requests use a valid/ready handshake, with one request in flight at a time. The result comes back as a one-cycle response pulse.

Top module: `dvma_xlate`

## Requirements
- R1: After reset the block is ready for a request, has no response or memory read pending, and the control register reads with enable 0 and range code 0.
- R2: Register select 0 is the control register: bit 0 is the enable, bits [4:2] the range code, bits [31:28] read as the fixed implementation code 3 and bits [27:24] as the fixed version code 1; all other bits read 0 and writes cannot change the fixed codes.
- R3: Range code n gives a window from 2^32 − 2^(24+n) to 0xFFFFFFFF; a translated request below the window start returns a fault with no memory read.
- R4: On a cache miss exactly one memory read is issued, at table base (select 1) plus four times ((vaddr − window start) >> 12), and the address is held until the read data returns.
- R5: A page entry supplies the physical page number in bits [26:8], which become physical address bits [30:12]; address bits [11:0] pass unchanged, bit 31 is 0, and the response cache flag is entry bit 7.
- R6: An entry with bit 1 (valid) clear faults, a write request to an entry with bit 2 (writeable) clear faults, and every fault response carries address 0 and cache flag 0.
- R7: A request whose page holds a cached valid entry is answered in the cycle after acceptance without a memory read.
- R8: A write of any data to select 2 invalidates every cached translation.
- R9: A write to select 3 invalidates only the cached translation whose page matches data bits [31:12]; other pages stay cached.
- R10: Select 4+s configures slot s: bit 0 set makes the slot bypass translation, returning {0, bit 1, vaddr[29:0]} with no fault, no memory read, and independent of enable and window.
- R11: With enable clear, every request from a non-bypass slot faults without a memory read.
- R12: The cache holds four pages with round-robin replacement of valid entries; an entry that faults as invalid is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | SEL_W | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write |
| req_slot | input | SLOT_W | Requesting bus slot |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_cache | output | 1 | Cacheable flag of the entry |
| mem_req | output | 1 | Table read pending |
| mem_addr | output | 32 | Table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Page entry read |

## Verification
The hardest state to reach is a cache that holds four pages while replacement, page flush and full flush interleave, combined with invalid entries that must never be cached. The bench's memory model computes entries from their address, so every fourth table slot is invalid and the writeable bit varies. Random requests over a twelve-page set with occasional flushes keep the cache churning, and a bench model of the cache predicts whether each request hits. Directed sequences fill five pages to force an eviction, and flush single pages between hits.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  localparam int PAGE_SH = 12;

  typedef struct packed {
    logic [19:0] vpn;
    logic [18:0] ppn;
    logic        cache;
    logic        wr_ok;
  } tlb_ent_t;

  typedef enum logic [0:0] {ST_IDLE, ST_FETCH} xl_state_t;

  function automatic logic [31:0] win_start(input logic [2:0] rng);
    return 32'hFFFF_FFFF << (24 + int'(rng));
  endfunction

  function automatic logic in_window(input logic [31:0] va, input logic [2:0] rng);
    return va >= win_start(rng);
  endfunction

  function automatic logic [31:0] entry_addr(input logic [31:0] base, input logic [31:0] va,
                                             input logic [2:0] rng);
    return base + (((va - win_start(rng)) >> PAGE_SH) << 2);
  endfunction

  function automatic logic [31:0] bypass_pa(input logic [31:0] va, input logic b30);
    return {1'b0, b30, va[29:0]};
  endfunction

  function automatic logic [31:0] mapped_pa(input logic [18:0] ppn, input logic [31:0] va);
    return {1'b0, ppn, va[11:0]};
  endfunction
endpackage

// File: rtl/dvma_regs.sv
module dvma_regs #(
  parameter int NUM_SLOTS = 4,
  parameter int SEL_W = 3,
  parameter logic [3:0] IMPL_CODE = 4'h3,
  parameter logic [3:0] VERS_CODE = 4'h1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [SEL_W-1:0]     sel,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 enable,
  output logic [2:0]           rng,
  output logic [31:0]          base,
  output logic [NUM_SLOTS-1:0] byp,
  output logic [NUM_SLOTS-1:0] b30,
  output logic                 flush_all,
  output logic                 flush_page,
  output logic [19:0]          flush_vpn
);
  localparam logic [SEL_W-1:0] SEL_CTRL  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_BASE  = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_FALL  = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_FPAGE = SEL_W'(3);

  logic unused_wbits;
  assign unused_wbits = ^{wdata[11:5], wdata[1]};

  assign flush_all  = wr && (sel == SEL_FALL);
  assign flush_page = wr && (sel == SEL_FPAGE);
  assign flush_vpn  = wdata[31:12];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
      rng    <= 3'd0;
      base   <= 32'd0;
    end else if (wr && sel == SEL_CTRL) begin
      enable <= wdata[0];
      rng    <= wdata[4:2];
    end else if (wr && sel == SEL_BASE) begin
      base <= wdata;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byp[s] <= 1'b0;
        b30[s] <= 1'b0;
      end else if (wr && sel == SEL_W'(4 + s)) begin
        byp[s] <= wdata[0];
        b30[s] <= wdata[1];
      end
    end
  end

  always_comb begin
    rdata = 32'd0;
    if (sel == SEL_CTRL) rdata = {IMPL_CODE, VERS_CODE, 19'd0, rng, 1'b0, enable};
    else if (sel == SEL_BASE) rdata = base;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (sel == SEL_W'(4 + s)) rdata = {30'd0, b30[s], byp[s]};
  end

  a_r2_fixed_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CTRL) |-> (rdata[31:24] == {IMPL_CODE, VERS_CODE}));
endmodule

// File: rtl/dvma_tlb.sv
module dvma_tlb
  import dvma_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] look_vpn,
  output logic        hit,
  output tlb_ent_t    hit_ent,
  input  logic        fill,
  input  tlb_ent_t    fill_ent,
  input  logic        flush_all,
  input  logic        flush_page,
  input  logic [19:0] flush_vpn
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  tlb_ent_t          ent [DEPTH];
  logic [DEPTH-1:0]  valid;
  logic [DEPTH-1:0]  match;
  logic [PW-1:0]     rr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match[i] = valid[i] && (ent[i].vpn == look_vpn);
  end

  assign hit = |match;

  always_comb begin
    hit_ent = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match[i]) hit_ent = hit_ent | ent[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      rr    <= '0;
    end else if (flush_all) begin
      valid <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (flush_page && ent[i].vpn == flush_vpn) valid[i] <= 1'b0;
      if (fill) begin
        ent[rr]   <= fill_ent;
        valid[rr] <= 1'b1;
        rr        <= (rr == PW'(DEPTH - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  a_r12_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid == '0));

  for (genvar i = 0; i < DEPTH; i++) begin : g_chk
    a_r9_page_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_page && !fill && !flush_all) |=>
        !(valid[i] && ent[i].vpn == $past(flush_vpn)));
  end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int TLB_DEPTH = 4,
  parameter logic [3:0] IMPL_CODE = 4'h3,
  parameter logic [3:0] VERS_CODE = 4'h1,
  localparam int SEL_W  = $clog2(4 + NUM_SLOTS),
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic              req_write,
  input  logic [SLOT_W-1:0] req_slot,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [31:0]       rsp_paddr,
  output logic              rsp_cache,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);
  logic                 enable;
  logic [2:0]           rng;
  logic [31:0]          base;
  logic [NUM_SLOTS-1:0] byp, b30;
  logic                 flush_all, flush_page;
  logic [19:0]          flush_vpn;

  dvma_regs #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W),
              .IMPL_CODE(IMPL_CODE), .VERS_CODE(VERS_CODE)) u_regs (
    .clk, .rst_n, .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata), .rdata(reg_rdata),
    .enable, .rng, .base, .byp, .b30, .flush_all, .flush_page, .flush_vpn
  );

  xl_state_t st;
  logic [31:0] q_va;
  logic        q_wr;

  // named events for the checks
  logic accept, is_byp, go_xlat, tlb_hit, fetch_done, pte_v, pte_w, fill;
  tlb_ent_t hit_ent, fill_ent;

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign is_byp     = byp[req_slot];
  assign go_xlat    = !is_byp && enable && in_window(req_vaddr, rng);
  assign fetch_done = (st == ST_FETCH) && mem_rvalid;
  assign pte_v      = mem_rdata[1];
  assign pte_w      = mem_rdata[2];
  assign fill       = fetch_done && pte_v;
  assign fill_ent   = '{vpn: q_va[31:12], ppn: mem_rdata[26:8],
                        cache: mem_rdata[7], wr_ok: pte_w};

  logic unused_pte_bits;
  assign unused_pte_bits = ^{mem_rdata[31:27], mem_rdata[6:3], mem_rdata[0]};

  dvma_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
    .clk, .rst_n, .look_vpn(req_vaddr[31:12]), .hit(tlb_hit), .hit_ent,
    .fill, .fill_ent, .flush_all, .flush_page, .flush_vpn
  );

  logic hit_flt, mem_flt;
  assign hit_flt = req_write && !hit_ent.wr_ok;
  assign mem_flt = !pte_v || (q_wr && !pte_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= 32'd0;
      rsp_cache <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= 32'd0;
      q_va      <= 32'd0;
      q_wr      <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (is_byp) begin
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b0;
          rsp_paddr <= bypass_pa(req_vaddr, b30[req_slot]);
          rsp_cache <= 1'b0;
        end else if (!go_xlat) begin
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b1;
          rsp_paddr <= 32'd0;
          rsp_cache <= 1'b0;
        end else if (tlb_hit) begin
          rsp_valid <= 1'b1;
          rsp_fault <= hit_flt;
          rsp_paddr <= hit_flt ? 32'd0 : mapped_pa(hit_ent.ppn, req_vaddr);
          rsp_cache <= hit_ent.cache && !hit_flt;
        end else begin
          st       <= ST_FETCH;
          mem_req  <= 1'b1;
          mem_addr <= entry_addr(base, req_vaddr, rng);
          q_va     <= req_vaddr;
          q_wr     <= req_write;
        end
      end else if (fetch_done) begin
        st        <= ST_IDLE;
        mem_req   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_fault <= mem_flt;
        rsp_paddr <= mem_flt ? 32'd0 : mapped_pa(mem_rdata[26:8], q_va);
        rsp_cache <= mem_rdata[7] && !mem_flt;
      end
    end
  end

  a_r4_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  a_r6_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'd0 && !rsp_cache));

  a_r5_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_paddr[31]);

  a_r10_bypass_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_byp) |=> (rsp_valid && !rsp_fault && !mem_req));

  a_r11_disabled_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_byp && !enable) |=> (rsp_valid && rsp_fault && !mem_req));

  a_r7_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && go_xlat && tlb_hit) |=> (rsp_valid && !mem_req));

  a_r3_outside_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_byp && !in_window(req_vaddr, rng)) |=> (rsp_valid && rsp_fault));
endmodule

// File: tb/test_dvma_xlate.sv
module test_dvma_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0] req_slot = '0;
  logic rsp_valid, rsp_fault, rsp_cache;
  logic [31:0] rsp_paddr;
  logic mem_req;
  logic [31:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0, checks = 0, cycles = 0, mem_reads = 0;
  logic [31:0] last_maddr = '0;
  int rd_wait = 0;

  dvma_xlate i_dvma_xlate (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench page table: content derived from entry address
  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [18:0] ppn = a[20:2] ^ 19'h2A5C3;
    logic c = a[4];
    logic w = a[5] ^ a[2];
    logic v = (a[3:2] != 2'b11);
    return {5'd0, ppn, c, 4'd0, w, v, 1'b0};
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
      rd_wait <= 0;
    end else if (mem_req) begin
      if (rd_wait == 2) begin
        mem_rvalid <= 1'b1;
        mem_rdata <= pte_of(mem_addr);
        last_maddr <= mem_addr;
        mem_reads <= mem_reads + 1;
      end else rd_wait <= rd_wait + 1;
    end
  end

  // bench model state
  logic m_en = 0;
  logic [2:0] m_rng = 0;
  logic [31:0] m_base = 0;
  logic [3:0] m_byp = 0, m_b30 = 0;
  logic [19:0] m_vpn [4];
  logic [31:0] m_pte [4];
  logic [3:0] m_v = 0;
  int m_rr = 0;

  function automatic logic [31:0] w_start(input logic [2:0] n);
    logic [63:0] sz = 64'h100_0000 << n;
    return 32'(64'h1_0000_0000 - sz);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    case (sel)
      3'd0: begin m_en = d[0]; m_rng = d[4:2]; end
      3'd1: m_base = d;
      3'd2: m_v = 0;
      3'd3: for (int i = 0; i < 4; i++) if (m_vpn[i] == d[31:12]) m_v[i] = 0;
      default: begin m_byp[sel-4] = d[0]; m_b30[sel-4] = d[1]; end
    endcase
  endtask

  task automatic rreg(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  // one request, checked against the model; returns whether a read happened
  task automatic xreq(input logic [1:0] slot, input logic [31:0] va, input bit wr, output bit missed);
    int lat, r0, hidx;
    bit exp_f, exp_miss, exp_c;
    logic [31:0] exp_pa, pte, ea;
    string tag;
    missed = 0;
    exp_miss = 0; exp_f = 0; exp_pa = 0; exp_c = 0; pte = 0; ea = 0;
    if (m_byp[slot]) begin
      tag = "R10"; exp_pa = {1'b0, m_b30[slot], 30'd0} | (va & 32'h3FFF_FFFF);
    end else if (!m_en) begin
      tag = "R11"; exp_f = 1;
    end else if (va < w_start(m_rng)) begin
      tag = "R3"; exp_f = 1;
    end else begin
      hidx = -1;
      for (int i = 0; i < 4; i++) if (m_v[i] && m_vpn[i] == va[31:12]) hidx = i;
      if (hidx >= 0) begin
        tag = "R7"; pte = m_pte[hidx];
      end else begin
        tag = "R4"; exp_miss = 1;
        ea = m_base + ((va - w_start(m_rng)) / 4096) * 4;
        pte = pte_of(ea);
        if (pte[1]) begin
          m_vpn[m_rr] = va[31:12]; m_pte[m_rr] = pte; m_v[m_rr] = 1;
          m_rr = (m_rr + 1) % 4;
        end
      end
      if (!pte[1] || (wr && !pte[2])) exp_f = 1;
      else begin
        exp_pa = (32'(pte[26:8]) << 12) | (va & 32'hFFF);
        exp_c = pte[7];
      end
    end
    r0 = mem_reads;
    @(negedge clk);
    check(req_ready === 1'b1, "R1", {31'd0, req_ready}, 1);
    req_valid = 1; req_vaddr = va; req_write = wr; req_slot = slot;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (rsp_valid !== 1'b1 && lat < 50) begin @(negedge clk); lat++; end
    check(rsp_valid === 1'b1, tag, {31'd0, rsp_valid}, 1);
    check(rsp_fault === exp_f, exp_f ? "R6" : tag, {31'd0, rsp_fault}, {31'd0, exp_f});
    check(rsp_paddr === exp_pa, "R5", rsp_paddr, exp_pa);
    check(rsp_cache === exp_c, "R5", {31'd0, rsp_cache}, {31'd0, exp_c});
    check((mem_reads - r0) == int'(exp_miss), exp_miss ? "R4" : "R12", mem_reads - r0, exp_miss);
    if (exp_miss) check(last_maddr === ea, "R4", last_maddr, ea);
    else check(lat == 1, "R7", lat, 1);
    missed = (mem_reads != r0);
  endtask

  initial begin
    bit m;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    check(req_ready === 1 && rsp_valid === 0 && mem_req === 0, "R1", {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
    rreg(3'd0, d);
    check(d === 32'h3100_0000, "R1", d, 32'h3100_0000);
    // R2 control layout
    wreg(3'd0, 32'hFFFF_FFFF);
    rreg(3'd0, d);
    check(d === 32'h3100_001D, "R2", d, 32'h3100_001D);
    wreg(3'd0, 32'h0000_0009);
    rreg(3'd0, d);
    check(d === 32'h3100_0009, "R2", d, 32'h3100_0009);
    wreg(3'd1, 32'h0010_0000);
    wreg(3'd6, 32'h0);          // slot 2 bypass, bit30 = 0
    wreg(3'd6, 32'h1);
    wreg(3'd7, 32'h3);          // slot 3 bypass, bit30 = 1
    rreg(3'd7, d);
    check(d === 32'h3, "R10", d, 32'h3);
    // R10 bypass
    xreq(2'd3, 32'h1234_5678, 1, m);
    xreq(2'd2, 32'hFFFF_0ABC, 0, m);
    // R3 window edges, range 2
    xreq(2'd0, 32'hFBFF_FFFC, 0, m);
    xreq(2'd0, 32'hFC00_0010, 0, m);
    xreq(2'd1, 32'hFFFF_F004, 0, m);
    // R7 hit
    xreq(2'd0, 32'hFC00_0FF0, 0, m);
    check(m == 0, "R7", m, 0);
    // R12 round robin: pages 1,2,4,5 then page 0 again
    xreq(2'd0, 32'hFC00_1000, 0, m);
    xreq(2'd0, 32'hFC00_2000, 1, m);
    xreq(2'd0, 32'hFC00_3000, 0, m); // invalid entry, not cached (R12)
    xreq(2'd0, 32'hFC00_3000, 0, m);
    check(m == 1, "R12", m, 1);
    xreq(2'd0, 32'hFC00_4000, 0, m);
    xreq(2'd0, 32'hFC00_5000, 0, m);
    xreq(2'd0, 32'hFC00_0000, 0, m);
    check(m == 1, "R12", m, 1);
    // R9 page flush
    wreg(3'd3, 32'hFC00_5123);
    xreq(2'd0, 32'hFC00_4000, 0, m);
    check(m == 0, "R9", m, 0);
    xreq(2'd0, 32'hFC00_5000, 0, m);
    check(m == 1, "R9", m, 1);
    // R8 flush all
    wreg(3'd2, 32'hDEAD_BEEF);
    xreq(2'd0, 32'hFC00_4000, 0, m);
    check(m == 1, "R8", m, 1);
    // R11 disable
    wreg(3'd0, 32'h0000_0008);
    xreq(2'd0, 32'hFC00_4000, 0, m);
    xreq(2'd3, 32'hFC00_4000, 0, m);
    // range 7 and range 0 corners
    wreg(3'd0, 32'h0000_001D);
    xreq(2'd1, 32'h8000_0000, 0, m);
    xreq(2'd1, 32'h7FFF_FFFF, 0, m);
    wreg(3'd0, 32'h0000_0001);
    xreq(2'd1, 32'hFEFF_FFFF, 0, m);
    xreq(2'd1, 32'hFF00_7000, 0, m);
    // random phase, range 2
    wreg(3'd0, 32'h0000_0009);
    wreg(3'd2, 32'h0);
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      logic [31:0] va;
      if (r < 4) wreg(3'd2, $urandom);
      else if (r < 9) wreg(3'd3, w_start(3'd2) + 32'($urandom_range(0, 11)) * 4096);
      else begin
        if (r < 15) va = w_start(3'd2) - 32'($urandom_range(1, 8192));
        else va = w_start(3'd2) + 32'($urandom_range(0, 11)) * 4096 + 32'($urandom_range(0, 4095));
        xreq(2'($urandom_range(0, 3)), va, 1'($urandom_range(0, 1)), m);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<%0d", cycles, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule